// File: doc/BRIEF.md
# Slot-Scheduled Transceiver Power-Up Sequencer

This block wakes an external narrowband transceiver once per time slot and prepares it for one burst. A free-running microsecond prescaler feeds a slot clock. The slot clock marks a boundary every slot period. At each boundary where the sequencer is powered down, it starts a burst. First it raises the supply-regulator enable and the transmit/receive select. After a fixed lead time it shifts a configuration word out over a three-wire serial link (data, clock, latch strobe). It then waits for the synthesizer loop to settle, with a settle time that depends on the direction. After that it raises the transmit or receive RF enable. It signals the packet engine with a one-cycle ready pulse at a fixed time after power-up, the same time for both directions. It holds the radio up for a programmable data window and then drops everything back to power-down.

Burst direction alternates from one slot boundary to the next. A device therefore transmits once and receives once every two slot periods, and its receive start is offset from its transmit start by one slot period. The role input decides which direction the first boundary takes. The receive word is normally the full width. When the transceiver is set to supply a recovered clock, only the upper part of the receive word is sent.

Top module: `rf_slot_sequencer`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output is low.
- R2: A slot boundary occurs every SLOT_US*CLK_PER_US clock cycles after reset release. A boundary seen while powered down raises reg_en and sets trx_sel one cycle later. The direction is mode_tx XOR a parity bit that starts at 0 and flips at every boundary, so the first boundary uses mode_tx and later boundaries alternate. A trx_sel value of 1 means transmit.
- R3: The serial transfer starts LEAD_US*CLK_PER_US cycles after reg_en rises. sclk, sdat and sstb stay low outside the transfer.
- R4: Each bit is sent MSB first. sclk is low for HALF_CYC cycles and then high for HALF_CYC cycles. sdat changes only together with a falling sclk. After the last falling edge, sstb is high for HALF_CYC cycles while sclk stays low.
- R5: A transmit burst sends all CFG_W bits of tx_word. A receive burst sends all CFG_W bits of rx_word, or only its upper RX_SHORT_BITS bits when rclk_mode was 1 at the boundary.
- R6: In a transmit burst, tx_on rises TX_SETTLE_US*CLK_PER_US+1 cycles after sstb falls and stays high to the end of the burst. rx_on stays low.
- R7: In a receive burst, rx_on rises RX_SETTLE_US*CLK_PER_US+1 cycles after sstb falls and stays high to the end of the burst. tx_on stays low.
- R8: burst_rdy is a single-cycle pulse exactly READY_US*CLK_PER_US cycles after reg_en rises, in both directions.
- R9: data_us*CLK_PER_US cycles after the ready pulse, all outputs return to low. A data_us of 0 counts as 1.
- R10: Changes to mode_tx, rclk_mode and data_us during a burst have no effect on that burst. A boundary that arrives while a burst is still running starts nothing, but it still flips the direction parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_tx | input | 1 | Role: direction of the first boundary (1 = transmit) |
| rclk_mode | input | 1 | Transceiver supplies recovered clock; shortens the receive word |
| tx_word | input | CFG_W | Transmit configuration word |
| rx_word | input | CFG_W | Receive configuration word |
| data_us | input | ACT_W | Data window after ready, in microseconds |
| reg_en | output | 1 | Supply-regulator enable |
| trx_sel | output | 1 | Transmit/receive select (1 = transmit) |
| sdat | output | 1 | Serial configuration data |
| sclk | output | 1 | Serial configuration clock |
| sstb | output | 1 | Serial latch strobe |
| tx_on | output | 1 | Transmitter enable |
| rx_on | output | 1 | Receiver enable |
| burst_rdy | output | 1 | One-cycle ready pulse to the packet engine |

## Verification
The hardest case to reach is a slot boundary that lands while a burst is still active. The rule that the parity still advances on that boundary is visible only in the direction of the burst after it. The stimulus sets a data window longer than the slot period, so one burst runs past the next boundary. The reference model then has to predict both the skipped boundary and the direction of the following burst. Mid-burst changes to the role, the recovered-clock flag and the window length are made a few dozen cycles after a burst starts, and the per-cycle comparison shows that the running burst keeps its latched settings.

// File: rtl/rfseq_pkg.sv
`timescale 1ns/1ps
package rfseq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_LEAD,
    ST_PROG,
    ST_SETTLE,
    ST_WAITRDY,
    ST_DATA
  } seq_state_t;

  typedef enum logic [1:0] {
    SH_IDLE,
    SH_LO,
    SH_HI,
    SH_STB
  } shift_state_t;
endpackage

// File: rtl/rfseq_us_tick.sv
`timescale 1ns/1ps
module rfseq_us_tick #(
  parameter int CLK_PER_US = 125
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

  generate
    if (CLK_PER_US == 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);
      logic [CW-1:0] div_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          div_q <= '0;
        end else if (div_q == LAST) begin
          div_q <= '0;
        end else begin
          div_q <= div_q + CW'(1);
        end
      end
      assign tick = (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/rfseq_slot_clock.sv
`timescale 1ns/1ps
module rfseq_slot_clock #(
  parameter int SLOT_US = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic slot_p
);
  localparam int UW = (SLOT_US > 1) ? $clog2(SLOT_US) : 1;
  localparam logic [UW-1:0] LAST = UW'(SLOT_US - 1);

  logic [UW-1:0] us_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      us_q   <= '0;
      slot_p <= 1'b0;
    end else begin
      slot_p <= tick && (us_q == LAST);
      if (tick) begin
        us_q <= (us_q == LAST) ? '0 : us_q + UW'(1);
      end
    end
  end
endmodule

// File: rtl/rfseq_serial_tx.sv
`timescale 1ns/1ps
module rfseq_serial_tx
  import rfseq_pkg::*;
#(
  parameter int W        = 16,
  parameter int HALF_CYC = 63,
  localparam int NBW     = $clog2(W + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   word,
  input  logic [NBW-1:0] nbits,
  output logic           sdat,
  output logic           sclk,
  output logic           sstb,
  output logic           done
);
  localparam int HW = $clog2(HALF_CYC + 1);
  localparam logic [HW-1:0] H_M1 = HW'(HALF_CYC - 1);

  shift_state_t   ph;
  logic [W-1:0]   sh;
  logic [NBW-1:0] left;
  logic [HW-1:0]  hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph   <= SH_IDLE;
      sh   <= '0;
      left <= '0;
      hcnt <= '0;
      sdat <= 1'b0;
      sclk <= 1'b0;
      sstb <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        SH_IDLE: begin
          if (start) begin
            sdat <= word[W-1];
            sh   <= {word[W-2:0], 1'b0};
            left <= nbits - NBW'(1);
            hcnt <= H_M1;
            sclk <= 1'b0;
            ph   <= SH_LO;
          end
        end
        SH_LO: begin
          if (hcnt == '0) begin
            hcnt <= H_M1;
            sclk <= 1'b1;
            ph   <= SH_HI;
          end else begin
            hcnt <= hcnt - HW'(1);
          end
        end
        SH_HI: begin
          if (hcnt == '0) begin
            hcnt <= H_M1;
            sclk <= 1'b0;
            if (left == '0) begin
              sdat <= 1'b0;
              sstb <= 1'b1;
              ph   <= SH_STB;
            end else begin
              left <= left - NBW'(1);
              sdat <= sh[W-1];
              sh   <= {sh[W-2:0], 1'b0};
              ph   <= SH_LO;
            end
          end else begin
            hcnt <= hcnt - HW'(1);
          end
        end
        SH_STB: begin
          if (hcnt == '0) begin
            sstb <= 1'b0;
            done <= 1'b1;
            ph   <= SH_IDLE;
          end else begin
            hcnt <= hcnt - HW'(1);
          end
        end
        default: ph <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rf_slot_sequencer.sv
`timescale 1ns/1ps
module rf_slot_sequencer
  import rfseq_pkg::*;
#(
  parameter int CLK_PER_US    = 125,
  parameter int SLOT_US       = 10000,
  parameter int LEAD_US       = 40,
  parameter int TX_SETTLE_US  = 200,
  parameter int RX_SETTLE_US  = 150,
  parameter int READY_US      = 395,
  parameter int HALF_CYC      = 63,
  parameter int CFG_W         = 16,
  parameter int RX_SHORT_BITS = 8,
  parameter int ACT_W         = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_tx,
  input  logic             rclk_mode,
  input  logic [CFG_W-1:0] tx_word,
  input  logic [CFG_W-1:0] rx_word,
  input  logic [ACT_W-1:0] data_us,
  output logic             reg_en,
  output logic             trx_sel,
  output logic             sdat,
  output logic             sclk,
  output logic             sstb,
  output logic             tx_on,
  output logic             rx_on,
  output logic             burst_rdy
);
  localparam int NBW       = $clog2(CFG_W + 1);
  localparam int LEAD_CYC  = LEAD_US * CLK_PER_US;
  localparam int TXS_CYC   = TX_SETTLE_US * CLK_PER_US;
  localparam int RXS_CYC   = RX_SETTLE_US * CLK_PER_US;
  localparam int RDY_CYC   = READY_US * CLK_PER_US;
  localparam int BURST_MAX = RDY_CYC + ((2 ** ACT_W) - 1) * CLK_PER_US;
  localparam int BW        = $clog2(BURST_MAX + 1);

  localparam logic [BW-1:0] LEAD_M1 = BW'(LEAD_CYC - 1);
  localparam logic [BW-1:0] TXS_M1  = BW'(TXS_CYC - 1);
  localparam logic [BW-1:0] RXS_M1  = BW'(RXS_CYC - 1);
  localparam logic [BW-1:0] RDY_M1  = BW'(RDY_CYC - 1);

  logic             tick;
  logic             slot_p;
  logic             par;
  seq_state_t       st;
  logic [BW-1:0]    cnt;
  logic [BW-1:0]    bcnt;
  logic             dir_tx;
  logic             short_q;
  logic [ACT_W-1:0] act_q;
  logic             ser_start;
  logic             ser_done;
  logic [CFG_W-1:0] ser_word;
  logic [NBW-1:0]   ser_nbits;

  rfseq_us_tick #(.CLK_PER_US(CLK_PER_US)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  rfseq_slot_clock #(.SLOT_US(SLOT_US)) u_slot (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .slot_p (slot_p)
  );

  assign ser_start = (st == ST_LEAD) && (cnt == '0);
  assign ser_word  = dir_tx ? tx_word : rx_word;
  assign ser_nbits = (!dir_tx && short_q) ? NBW'(RX_SHORT_BITS) : NBW'(CFG_W);

  rfseq_serial_tx #(.W(CFG_W), .HALF_CYC(HALF_CYC)) u_ser (
    .clk   (clk),
    .rst   (rst),
    .start (ser_start),
    .word  (ser_word),
    .nbits (ser_nbits),
    .sdat  (sdat),
    .sclk  (sclk),
    .sstb  (sstb),
    .done  (ser_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_OFF;
      par       <= 1'b0;
      cnt       <= '0;
      bcnt      <= '0;
      dir_tx    <= 1'b0;
      short_q   <= 1'b0;
      act_q     <= '0;
      reg_en    <= 1'b0;
      trx_sel   <= 1'b0;
      tx_on     <= 1'b0;
      rx_on     <= 1'b0;
      burst_rdy <= 1'b0;
    end else begin
      burst_rdy <= 1'b0;
      if (slot_p) begin
        par <= ~par;
      end
      if (st != ST_OFF) begin
        bcnt <= bcnt + BW'(1);
      end
      unique case (st)
        ST_OFF: begin
          if (slot_p) begin
            st      <= ST_LEAD;
            dir_tx  <= mode_tx ^ par;
            trx_sel <= mode_tx ^ par;
            reg_en  <= 1'b1;
            short_q <= rclk_mode;
            act_q   <= (data_us == '0) ? ACT_W'(1) : data_us;
            cnt     <= LEAD_M1;
            bcnt    <= '0;
          end
        end
        ST_LEAD: begin
          if (cnt == '0) begin
            st <= ST_PROG;
          end else begin
            cnt <= cnt - BW'(1);
          end
        end
        ST_PROG: begin
          if (ser_done) begin
            st  <= ST_SETTLE;
            cnt <= dir_tx ? TXS_M1 : RXS_M1;
          end
        end
        ST_SETTLE: begin
          if (cnt == '0) begin
            st    <= ST_WAITRDY;
            tx_on <= dir_tx;
            rx_on <= ~dir_tx;
          end else begin
            cnt <= cnt - BW'(1);
          end
        end
        ST_WAITRDY: begin
          if (bcnt >= RDY_M1) begin
            st        <= ST_DATA;
            burst_rdy <= 1'b1;
            cnt       <= BW'(act_q) * BW'(CLK_PER_US) - BW'(1);
          end
        end
        ST_DATA: begin
          if (cnt == '0) begin
            st      <= ST_OFF;
            reg_en  <= 1'b0;
            trx_sel <= 1'b0;
            tx_on   <= 1'b0;
            rx_on   <= 1'b0;
          end else begin
            cnt <= cnt - BW'(1);
          end
        end
        default: st <= ST_OFF;
      endcase
    end
  end
endmodule

// File: rtl/rf_slot_sequencer_chk.sv
`timescale 1ns/1ps
module rf_slot_sequencer_chk #(
  parameter int CFG_W = 16,
  parameter int ACT_W = 12
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_tx,
  input logic             rclk_mode,
  input logic [CFG_W-1:0] tx_word,
  input logic [CFG_W-1:0] rx_word,
  input logic [ACT_W-1:0] data_us,
  input logic             reg_en,
  input logic             trx_sel,
  input logic             sdat,
  input logic             sclk,
  input logic             sstb,
  input logic             tx_on,
  input logic             rx_on,
  input logic             burst_rdy
);
  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(tx_on && rx_on)); // R7
  AST_RF_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    (tx_on || rx_on) |-> reg_en); // R6
  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    burst_rdy |=> !burst_rdy); // R8
  AST_READY_AFTER_RF: assert property (@(posedge clk) disable iff (rst)
    burst_rdy |-> (tx_on || rx_on)); // R8
  AST_SERIAL_QUIET_OFF: assert property (@(posedge clk) disable iff (rst)
    !reg_en |-> (!sclk && !sstb && !sdat)); // R3
  AST_STROBE_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    sstb |-> !sclk); // R4
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (reg_en && $past(reg_en)) |-> $stable(trx_sel)); // R10
  AST_RF_AFTER_SERIAL: assert property (@(posedge clk) disable iff (rst)
    (tx_on || rx_on) |-> (!sstb && !sclk)); // R6
  AST_OFF_CLEARS_RF: assert property (@(posedge clk) disable iff (rst)
    $fell(reg_en) |-> (!tx_on && !rx_on)); // R9
endmodule

bind rf_slot_sequencer rf_slot_sequencer_chk #(.CFG_W(CFG_W), .ACT_W(ACT_W)) u_chk (.*);

// File: tb/rf_slot_sequencer_test.sv
`timescale 1ns/1ps
module rf_slot_sequencer_test;
  localparam int C    = 4;
  localparam int S    = 80;
  localparam int LUS  = 4;
  localparam int TXS  = 20;
  localparam int RXS  = 15;
  localparam int RUS  = 48;
  localparam int H    = 2;
  localparam int SHB  = 8;
  localparam int CS   = C * S;
  localparam int L    = LUS * C;
  localparam int R    = RUS * C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_tx = 1'b1;
  logic        rclk_mode = 1'b0;
  logic [15:0] tx_word = 16'hA5C3;
  logic [15:0] rx_word = 16'h3C96;
  logic [11:0] data_us = 12'd10;
  logic reg_en, trx_sel, sdat, sclk, sstb, tx_on, rx_on, burst_rdy;

  int vectors = 0;
  int errors = 0;
  bit finished = 1'b0;

  // behavioural reference state
  int k = 0;
  int t0 = 0;
  int tot = 0;
  bit started = 1'b0;
  bit par = 1'b0;
  bit d = 1'b0;
  bit shortm = 1'b0;
  logic [15:0] mword = '0;
  bit e_reg, e_sel, e_dat, e_clk, e_stb, e_tx, e_rx, e_rdy;

  always #4 clk = ~clk;

  rf_slot_sequencer #(
    .CLK_PER_US(C), .SLOT_US(S), .LEAD_US(LUS), .TX_SETTLE_US(TXS),
    .RX_SETTLE_US(RXS), .READY_US(RUS), .HALF_CYC(H), .CFG_W(16),
    .RX_SHORT_BITS(SHB), .ACT_W(12)
  ) uut (
    .clk(clk), .rst(rst), .mode_tx(mode_tx), .rclk_mode(rclk_mode),
    .tx_word(tx_word), .rx_word(rx_word), .data_us(data_us),
    .reg_en(reg_en), .trx_sel(trx_sel), .sdat(sdat), .sclk(sclk),
    .sstb(sstb), .tx_on(tx_on), .rx_on(rx_on), .burst_rdy(burst_rdy)
  );

  always @(posedge clk) begin
    if (rst) begin
      k = 0; started = 1'b0; par = 1'b0;
    end else begin
      k = k + 1;
      // R2: boundary pulse follows every CS cycles; R10: ignored while busy
      if ((k - 1) > 0 && ((k - 1) % CS) == 0) begin
        if (!(started && (k - 1) < t0 + tot)) begin
          started = 1'b1;
          t0      = k;
          d       = mode_tx ^ par;
          shortm  = rclk_mode;
          mword   = (mode_tx ^ par) ? tx_word : rx_word;
          tot     = R + ((data_us == 0) ? 1 : int'(data_us)) * C;
        end
        par = !par;
      end
    end
    e_reg = 0; e_sel = 0; e_dat = 0; e_clk = 0; e_stb = 0;
    e_tx = 0; e_rx = 0; e_rdy = 0;
    if (!rst && started && (k - t0) < tot) begin
      int j, q, n, span, en_at;
      j = k - t0;
      q = j - L;
      n = (!d && shortm) ? SHB : 16;
      span = 2 * H * n;
      en_at = L + span + H + 1 + (d ? TXS : RXS) * C;
      e_reg = 1; e_sel = d;
      if (q >= 0 && q < span) begin
        e_clk = (q % (2 * H)) >= H;
        e_dat = mword[15 - q / (2 * H)];
      end
      e_stb = (q >= span) && (q < span + H);
      e_tx = d && (j >= en_at);
      e_rx = !d && (j >= en_at);
      e_rdy = (j == R);
    end
  end

  task automatic chk(input string tag, input string nm, input logic a, input bit e);
    if (a !== e) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b at cycle %0d", tag, nm, a, e, k);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      vectors++;
      if (rst) begin
        // R1: everything low in reset
        chk("R1", "reg_en", reg_en, 0);   chk("R1", "trx_sel", trx_sel, 0);
        chk("R1", "sdat", sdat, 0);       chk("R1", "sclk", sclk, 0);
        chk("R1", "sstb", sstb, 0);       chk("R1", "tx_on", tx_on, 0);
        chk("R1", "rx_on", rx_on, 0);     chk("R1", "burst_rdy", burst_rdy, 0);
      end else begin
        chk("R2 R9", "reg_en", reg_en, e_reg);
        chk("R2 R10", "trx_sel", trx_sel, e_sel);
        chk("R4 R5", "sdat", sdat, e_dat);
        chk("R3 R4", "sclk", sclk, e_clk);
        chk("R4", "sstb", sstb, e_stb);
        chk("R6", "tx_on", tx_on, e_tx);
        chk("R7", "rx_on", rx_on, e_rx);
        chk("R8", "burst_rdy", burst_rdy, e_rdy);
      end
    end
  end

  task automatic wait_to(input int kk);
    while (k < kk) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    wait_to(1000);  mode_tx = 1'b0;        // R10: role flip mid-burst
    wait_to(1400);  rclk_mode = 1'b1;      // R5: short receive word next
    wait_to(1700);  data_us = 12'd0;       // R9: zero window counts as one
    wait_to(2000);  data_us = 12'd40;      // R10: burst overruns a boundary
    wait_to(2300);  rclk_mode = 1'b0; mode_tx = 1'b1;
    wait_to(3250);  tx_word = 16'h8001; rx_word = 16'h7FFE; data_us = 12'd10;
    wait_to(4700);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion at cycle %0d", k);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule